// File: doc/BRIEF.md
# Interrupt Pin Router

The router watches a bank of interrupt pins and turns each low-to-high transition into one delivery message for a set of processors. Every pin has a routing entry, supplied on a flat input bus, that holds a mask bit, a trigger bit, a polarity bit, a destination-mode bit, a three-bit delivery mode, an eight-bit vector and an eight-bit destination. A captured event whose entry is masked is discarded. Otherwise the router builds a message from the entry and resolves which processors receive it.

Target resolution has two modes. In physical mode the destination is a processor number, and the value 0xFF reaches every processor. In logical mode each processor's logical-destination byte is ANDed with the destination, and every processor with a nonzero result is selected. Lowest-priority delivery in logical mode narrows that set to a single processor by rotating an offset through the matches. The message goes out on a valid/ready handshake, together with a target bitmask that has one bit per processor.

The control is a three-state machine. ST_IDLE takes the lowest-numbered pending pin. The transition IDLE_TO_RESOLVE applies when the pin's entry is unmasked, and IDLE_DROP keeps the machine in ST_IDLE when it is masked. ST_RESOLVE computes the targets. RESOLVE_TO_OFFER applies when the target set is nonempty. RESOLVE_FAULT returns to ST_IDLE with an error pulse. RESOLVE_EMPTY returns to ST_IDLE silently. ST_OFFER holds the message until OFFER_DONE on ready, which returns to ST_IDLE.

Top module: `irq_router`

## Requirements
- R1: A message is produced only on a low-to-high transition of a pin. A pin that stays high produces no further message, and a high-to-low transition produces none.
- R2: An entry with its mask bit (bit 22 of the entry) set makes the event vanish: no message and no error pulse.
- R3: When the delivery mode (entry bits 18:16) is 3'b111, the message vector is `ext_vector_i`, sampled when the pin is taken. For any other mode the vector is the entry's vector field (bits 15:8).
- R4: The message copies the destination (bits 7:0), the delivery mode, the destination mode (bit 19, 1 = logical), the trigger (bit 21) and the polarity (bit 20), the last of these as the level output.
- R5: In physical mode, destination 0xFF gives a target mask with all bits set. Any other value d gives only bit d. If d is not below NUM_CPUS, the target mask is empty and no message is sent.
- R6: Physical mode combined with delivery mode 3'b001 (lowest priority) sends no message and raises `lowpri_err_o` for exactly one cycle.
- R7: In logical mode, target bit i is set exactly when byte i of `cpu_ldr_i` ANDed with the destination is nonzero.
- R8: For lowest-priority delivery in logical mode, the message targets only the match at position (offset mod match count), counted in ascending processor order. The offset is then incremented. The offset is 0 after reset.
- R9: Logical mode with no matching processor sends no message and leaves the offset unchanged.
- R10: Pending events are served lowest pin number first, one message per accepted handshake. A valid message holds all its fields until it is accepted.
- R11: After reset `msg_valid_o` and `lowpri_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NUM_PINS | Interrupt pins |
| route_tbl_i | input | NUM_PINS*23 | Routing entries, pin p at bits [p*23 +: 23] |
| cpu_ldr_i | input | NUM_CPUS*8 | Logical-destination byte of each processor, processor i at [i*8 +: 8] |
| ext_vector_i | input | 8 | Vector from the external legacy controller |
| msg_ready_i | input | 1 | Consumer accepts the message |
| msg_valid_o | output | 1 | Message available |
| msg_vector_o | output | 8 | Message vector |
| msg_delivery_o | output | 3 | Delivery mode |
| msg_dest_mode_o | output | 1 | Destination mode, 1 = logical |
| msg_level_o | output | 1 | Level bit (entry polarity) |
| msg_trigger_o | output | 1 | Trigger bit |
| msg_dest_o | output | 8 | Destination field |
| msg_targets_o | output | NUM_CPUS | Resolved processor mask |
| lowpri_err_o | output | 1 | One-cycle pulse for lowest priority in physical mode |

## Verification
The assertions check several properties on every cycle. An offered message stays frozen while it waits for ready. It never carries an empty target mask. A lowest-priority logical message names exactly one processor. The error pulse never coincides with a valid message. The rotation offset moves by at most one per cycle. The rest can only be shown by the bench's scenarios, because each needs a known input history: the edge-only triggering, mask dropping, the vector source, field copying, broadcast and unicast targets, AND-matching, the rotation sequence, the offset left untouched by an empty match, and the pin service order.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef struct packed {
        logic       mask;       // 22
        logic       trigger;    // 21
        logic       polarity;   // 20
        logic       dest_mode;  // 19, 1 = logical
        logic [2:0] delivery;   // 18:16
        logic [7:0] vector;     // 15:8
        logic [7:0] dest;       // 7:0
    } route_entry_t;

    localparam int ENTRY_W = $bits(route_entry_t);

    localparam logic [2:0] DLV_FIXED  = 3'b000;
    localparam logic [2:0] DLV_LOWPRI = 3'b001;
    localparam logic [2:0] DLV_EXTINT = 3'b111;
    localparam logic [7:0] DEST_BCAST = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_OFFER   = 2'd2
    } router_state_t;

endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] clr_i,
    output logic [NUM_PINS-1:0] pend_o
);
    logic [NUM_PINS-1:0] pin_q;
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] rise;

    assign rise   = pin_i & ~pin_q;
    assign pend_o = pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= '0;
            pend_q <= '0;
        end else begin
            pin_q  <= pin_i;
            pend_q <= (pend_q & ~clr_i) | rise;
        end
    end

    // Only one pending event is taken per cycle.
    assert_clear_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_i));

    // A pending bit appears only after a low-to-high transition of its pin.
    assert_pend_needs_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~($past(pin_i) & ~$past(pin_q))) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_PINS = 8,
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [NUM_PINS-1:0] req_i,
    output logic [NUM_PINS-1:0] gnt_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic                any_o
);
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o = '0;
                gnt_o[i] = 1'b1;
                idx_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_target_resolver.sv
module irq_target_resolver
    import irq_router_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int OFS_W    = 16,
    localparam int CNT_W   = $clog2(NUM_CPUS + 1)
) (
    input  logic                  dest_mode_i,
    input  logic [2:0]            delivery_i,
    input  logic [7:0]            dest_i,
    input  logic [NUM_CPUS*8-1:0] cpu_ldr_i,
    input  logic [OFS_W-1:0]      offset_i,
    output logic [NUM_CPUS-1:0]   targets_o,
    output logic                  fault_o,
    output logic                  advance_o
);
    logic [NUM_CPUS-1:0] phys_set;
    logic [NUM_CPUS-1:0] logic_set;
    logic [NUM_CPUS-1:0] rot_pick;
    logic [CNT_W-1:0]    match_cnt;
    logic [OFS_W-1:0]    rot_pos;
    logic                is_lowpri;

    assign is_lowpri = (delivery_i == DLV_LOWPRI);

    genvar g;
    generate
        for (g = 0; g < NUM_CPUS; g++) begin : g_cpu
            assign logic_set[g] = (cpu_ldr_i[g*8 +: 8] & dest_i) != 8'h00;
            assign phys_set[g]  = (dest_i == DEST_BCAST) || (dest_i == 8'(g));
        end
    endgenerate

    always_comb begin
        match_cnt = '0;
        for (int i = 0; i < NUM_CPUS; i++) begin
            match_cnt = match_cnt + CNT_W'(logic_set[i]);
        end
    end

    assign rot_pos = (match_cnt == '0) ? '0 : (offset_i % OFS_W'(match_cnt));

    always_comb begin
        logic [OFS_W-1:0] seen;
        seen     = '0;
        rot_pick = '0;
        for (int i = 0; i < NUM_CPUS; i++) begin
            if (logic_set[i]) begin
                if (seen == rot_pos) rot_pick[i] = 1'b1;
                seen = seen + 1'b1;
            end
        end
    end

    always_comb begin
        fault_o   = 1'b0;
        advance_o = 1'b0;
        if (dest_mode_i) begin
            targets_o = is_lowpri ? rot_pick : logic_set;
            advance_o = is_lowpri && (match_cnt != '0);
        end else begin
            fault_o   = is_lowpri;
            targets_o = is_lowpri ? '0 : phys_set;
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_CPUS = 4,
    parameter int OFS_W    = 16,
    localparam int TBL_W   = NUM_PINS * ENTRY_W,
    localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic [TBL_W-1:0]      route_tbl_i,
    input  logic [NUM_CPUS*8-1:0] cpu_ldr_i,
    input  logic [7:0]            ext_vector_i,
    input  logic                  msg_ready_i,
    output logic                  msg_valid_o,
    output logic [7:0]            msg_vector_o,
    output logic [2:0]            msg_delivery_o,
    output logic                  msg_dest_mode_o,
    output logic                  msg_level_o,
    output logic                  msg_trigger_o,
    output logic [7:0]            msg_dest_o,
    output logic [NUM_CPUS-1:0]   msg_targets_o,
    output logic                  lowpri_err_o
);
    router_state_t state_q, state_d;

    route_entry_t        tbl [NUM_PINS];
    route_entry_t        ent_q;
    logic [7:0]          vec_q;
    logic [NUM_CPUS-1:0] tgt_q;
    logic [OFS_W-1:0]    ofs_q;
    logic                err_q;

    logic [NUM_PINS-1:0] pend;
    logic [NUM_PINS-1:0] gnt;
    logic [NUM_PINS-1:0] clr;
    logic [IDX_W-1:0]    pick_idx;
    logic                pick_any;
    logic [NUM_CPUS-1:0] res_targets;
    logic                res_fault;
    logic                res_advance;
    route_entry_t        cur_ent;

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_tbl
            assign tbl[g] = route_entry_t'(route_tbl_i[g*ENTRY_W +: ENTRY_W]);
        end
    endgenerate

    irq_pin_tracker #(.NUM_PINS(NUM_PINS)) u_tracker (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .clr_i (clr),
        .pend_o(pend)
    );

    irq_prio_pick #(.NUM_PINS(NUM_PINS)) u_pick (
        .req_i(pend),
        .gnt_o(gnt),
        .idx_o(pick_idx),
        .any_o(pick_any)
    );

    irq_target_resolver #(.NUM_CPUS(NUM_CPUS), .OFS_W(OFS_W)) u_resolve (
        .dest_mode_i(ent_q.dest_mode),
        .delivery_i (ent_q.delivery),
        .dest_i     (ent_q.dest),
        .cpu_ldr_i  (cpu_ldr_i),
        .offset_i   (ofs_q),
        .targets_o  (res_targets),
        .fault_o    (res_fault),
        .advance_o  (res_advance)
    );

    assign cur_ent = tbl[pick_idx];
    assign clr     = (state_q == ST_IDLE) ? gnt : '0;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_any && !cur_ent.mask) state_d = ST_RESOLVE;   // IDLE_TO_RESOLVE
            end
            ST_RESOLVE: begin
                if (res_fault)                state_d = ST_IDLE;       // RESOLVE_FAULT
                else if (res_targets == '0)   state_d = ST_IDLE;       // RESOLVE_EMPTY
                else                          state_d = ST_OFFER;      // RESOLVE_TO_OFFER
            end
            ST_OFFER: begin
                if (msg_ready_i)              state_d = ST_IDLE;       // OFFER_DONE
            end
            default:                          state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Message and rotation registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
            vec_q <= '0;
            tgt_q <= '0;
            ofs_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (pick_any) begin
                        ent_q <= cur_ent;
                        vec_q <= (cur_ent.delivery == DLV_EXTINT) ? ext_vector_i : cur_ent.vector;
                    end
                end
                ST_RESOLVE: begin
                    tgt_q <= res_targets;
                    err_q <= res_fault;
                    if (res_advance) ofs_q <= ofs_q + 1'b1;
                end
                ST_OFFER: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        msg_valid_o     = (state_q == ST_OFFER);
        msg_vector_o    = vec_q;
        msg_delivery_o  = ent_q.delivery;
        msg_dest_mode_o = ent_q.dest_mode;
        msg_level_o     = ent_q.polarity;
        msg_trigger_o   = ent_q.trigger;
        msg_dest_o      = ent_q.dest;
        msg_targets_o   = tgt_q;
        lowpri_err_o    = err_q;
    end

    assert_hold_until_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_targets_o)
            && $stable(msg_vector_o) && $stable(msg_dest_o) && $stable(msg_delivery_o));

    assert_targets_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> msg_targets_o != '0);

    assert_lowpri_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o && msg_dest_mode_o && msg_delivery_o == DLV_LOWPRI
            |-> $countones(msg_targets_o) == 1);

    assert_err_without_msg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lowpri_err_o |-> !msg_valid_o);

    assert_offset_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ofs_q == $past(ofs_q)) || (ofs_q == $past(ofs_q) + 1'b1));
endmodule

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
    import irq_router_pkg::*;

    localparam int NP = 8;
    localparam int NC = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     pin = '0;
    logic [NP*ENTRY_W-1:0] tbl;
    logic [NC*8-1:0]   ldr = '0;
    logic [7:0]        ext_vec = 8'h00;
    logic              ready = 1'b0;
    logic              valid;
    logic [7:0]        vec;
    logic [2:0]        dlv;
    logic              dmode, lvl, trg;
    logic [7:0]        dest;
    logic [NC-1:0]     tgts;
    logic              err;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_router #(.NUM_PINS(NP), .NUM_CPUS(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .route_tbl_i(tbl),
        .cpu_ldr_i(ldr), .ext_vector_i(ext_vec), .msg_ready_i(ready),
        .msg_valid_o(valid), .msg_vector_o(vec), .msg_delivery_o(dlv),
        .msg_dest_mode_o(dmode), .msg_level_o(lvl), .msg_trigger_o(trg),
        .msg_dest_o(dest), .msg_targets_o(tgts), .lowpri_err_o(err)
    );

    always @(posedge clk) begin
        cycles++;
        if (rst_n && err) err_seen++;
    end

    initial begin
        while (!done && cycles < 100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic route_entry_t mk(logic m, logic t, logic p, logic dm,
                                        logic [2:0] d, logic [7:0] v, logic [7:0] ds);
        route_entry_t e;
        e.mask = m; e.trigger = t; e.polarity = p; e.dest_mode = dm;
        e.delivery = d; e.vector = v; e.dest = ds;
        return e;
    endfunction

    task automatic set_entry(int p, route_entry_t e);
        @(negedge clk);
        tbl[p*ENTRY_W +: ENTRY_W] = e;
    endtask

    task automatic raise(int p);
        @(negedge clk); pin[p] = 1'b1;
    endtask

    task automatic lower(int p);
        @(negedge clk); pin[p] = 1'b0;
    endtask

    task automatic accept();
        @(negedge clk); ready = 1'b1;
        @(negedge clk); ready = 1'b0;
    endtask

    // Wait for a message, compare vector and targets, then accept it.
    task automatic expect_msg(string tag, logic [7:0] ev, logic [NC-1:0] et);
        int n = 0;
        @(negedge clk);
        while (!valid && n < 20) begin @(negedge clk); n++; end
        chk({tag, " valid"}, 32'(valid), 32'd1);
        chk({tag, " vector"}, 32'(vec), 32'(ev));
        chk({tag, " targets"}, 32'(tgts), 32'(et));
        accept();
    endtask

    task automatic expect_none(string tag);
        int seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (valid) seen++;
        end
        chk({tag, " no message"}, 32'(seen), 32'd0);
    endtask

    task automatic t_reset();
        chk("R11 reset valid", 32'(valid), 32'd0);
        chk("R11 reset err", 32'(err), 32'd0);
    endtask

    task automatic t_edge();
        set_entry(0, mk(0, 0, 0, 0, DLV_FIXED, 8'h20, 8'd2));
        raise(0);
        expect_msg("R1 first edge", 8'h20, 4'b0100);
        expect_none("R1 held high");
        lower(0);
        expect_none("R1 falling");
        raise(0);
        expect_msg("R1 second edge", 8'h20, 4'b0100);
        lower(0);
    endtask

    task automatic t_mask();
        int e0 = err_seen;
        set_entry(1, mk(1, 0, 0, 0, DLV_FIXED, 8'h21, 8'd0));
        raise(1);
        expect_none("R2 masked");
        chk("R2 no error pulse", 32'(err_seen - e0), 32'd0);
        lower(1);
    endtask

    task automatic t_vector();
        ext_vec = 8'h5A;
        set_entry(2, mk(0, 0, 0, 0, DLV_EXTINT, 8'h33, 8'd0));
        raise(2);
        expect_msg("R3 external vector", 8'h5A, 4'b0001);
        lower(2);
        set_entry(2, mk(0, 0, 0, 0, DLV_FIXED, 8'h33, 8'd0));
        raise(2);
        expect_msg("R3 entry vector", 8'h33, 4'b0001);
        lower(2);
    endtask

    task automatic t_fields();
        set_entry(4, mk(0, 1, 1, 0, 3'b100, 8'h44, 8'd1));
        raise(4);
        @(negedge clk);
        while (!valid) @(negedge clk);
        chk("R4 delivery", 32'(dlv), 32'h4);
        chk("R4 level", 32'(lvl), 32'd1);
        chk("R4 trigger", 32'(trg), 32'd1);
        chk("R4 dest mode", 32'(dmode), 32'd0);
        chk("R4 dest", 32'(dest), 32'd1);
        accept();
        lower(4);
    endtask

    task automatic t_phys();
        set_entry(5, mk(0, 0, 0, 0, DLV_FIXED, 8'h55, 8'hFF));
        raise(5); expect_msg("R5 broadcast", 8'h55, 4'b1111); lower(5);
        set_entry(5, mk(0, 0, 0, 0, DLV_FIXED, 8'h56, 8'd3));
        raise(5); expect_msg("R5 unicast", 8'h56, 4'b1000); lower(5);
        set_entry(5, mk(0, 0, 0, 0, DLV_FIXED, 8'h57, 8'd9));
        raise(5); expect_none("R5 out of range"); lower(5);
    endtask

    task automatic t_lpphys();
        int e0 = err_seen;
        set_entry(6, mk(0, 0, 0, 0, DLV_LOWPRI, 8'h66, 8'd1));
        raise(6);
        expect_none("R6 lowpri physical");
        chk("R6 error pulses", 32'(err_seen - e0), 32'd1);
        lower(6);
    endtask

    task automatic t_logical();
        set_entry(7, mk(0, 0, 0, 1, DLV_FIXED, 8'h77, 8'h02));
        raise(7); expect_msg("R7 logical match", 8'h77, 4'b1010); lower(7);
    endtask

    task automatic t_nomatch();
        set_entry(7, mk(0, 0, 0, 1, DLV_LOWPRI, 8'h78, 8'h80));
        raise(7); expect_none("R9 no match"); lower(7);
    endtask

    task automatic t_rotate();
        logic [NC-1:0] seq [4] = '{4'b0001, 4'b0010, 4'b1000, 4'b0001};
        set_entry(7, mk(0, 0, 0, 1, DLV_LOWPRI, 8'h79, 8'h03));
        for (int k = 0; k < 4; k++) begin
            raise(7);
            expect_msg($sformatf("R8 rotation step %0d (R9 offset kept)", k), 8'h79, seq[k]);
            lower(7);
        end
        set_entry(7, mk(0, 0, 0, 1, DLV_LOWPRI, 8'h7A, 8'h04));
        raise(7); expect_msg("R8 single match", 8'h7A, 4'b0100); lower(7);
    endtask

    task automatic t_order();
        logic [7:0] v0;
        set_entry(3, mk(0, 0, 0, 0, DLV_FIXED, 8'hA3, 8'd0));
        set_entry(5, mk(0, 0, 0, 0, DLV_FIXED, 8'hA5, 8'd1));
        set_entry(6, mk(0, 0, 0, 0, DLV_FIXED, 8'hA6, 8'd2));
        @(negedge clk);
        pin[3] = 1'b1; pin[5] = 1'b1; pin[6] = 1'b1;
        @(negedge clk);
        while (!valid) @(negedge clk);
        v0 = vec;
        repeat (4) @(negedge clk);
        chk("R10 held valid", 32'(valid), 32'd1);
        chk("R10 held vector", 32'(vec), 32'(v0));
        expect_msg("R10 order first", 8'hA3, 4'b0001);
        expect_msg("R10 order second", 8'hA5, 4'b0010);
        expect_msg("R10 order third", 8'hA6, 4'b0100);
        @(negedge clk);
        pin = '0;
    endtask

    initial begin
        for (int p = 0; p < NP; p++)
            tbl[p*ENTRY_W +: ENTRY_W] = mk(1, 0, 0, 0, DLV_FIXED, 8'h00, 8'h00);
        ldr = {8'h03, 8'h04, 8'h02, 8'h01};
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_mask();
        t_vector();
        t_fields();
        t_phys();
        t_lpphys();
        t_logical();
        t_nomatch();
        t_rotate();
        t_order();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule